// File: doc/BRIEF.md
# Interrupt Pin Delivery and EOI Engine

This block watches a bank of interrupt input lines, keeps one pending bit per line, and turns each request into a message-signalled interrupt. Each line has a 64-bit routing entry, supplied on a flat input bus. The entry gives the vector, the delivery mode, the destination, the destination mode, the trigger mode and a mask. The block delivers a request as one 32-bit address and one 32-bit data word on a valid/ready output. Only one message is outstanding at a time.

Level-triggered lines are throttled by a per-line remote-IRR flag. The flag is set when a message is sent and is cleared only by an end-of-interrupt (EOI) broadcast whose vector matches the entry. If the line is still asserted and unmasked when that EOI arrives, the line is delivered again. Edge-triggered lines latch a rising edge into the pending bit, but only while unmasked, and they never hold remote IRR. When a line's delivery mode selects an external legacy controller, the vector comes from a dedicated input instead of the entry.

Control is a two-state machine:
- `ST_SCAN` looks for the lowest-numbered eligible line. When it finds one it takes the transition *grant*: it latches the message, updates the pending and remote-IRR state, and moves to `ST_SEND`.
- `ST_SEND` drives `msg_valid` and holds the message. On `msg_ready` it takes the transition *accept* and returns to `ST_SCAN`.
- With no eligible line, `ST_SCAN` stays in `ST_SCAN` (*idle*). Without `msg_ready`, `ST_SEND` stays in `ST_SEND` (*stall*).

Top module: `irq_route_engine`

## Requirements
- R1: For a line whose entry has trigger bit 15 = 1 (level), `pending` shows the input level sampled at the previous clock edge, whatever the mask and remote IRR.
- R2: For a line whose entry has bit 15 = 0 (edge), a rising input edge sets `pending` only if mask bit 16 is 0. A rising edge seen while masked is lost: it does not become pending and it produces no message after a later unmask.
- R3: Granting an edge line clears its pending bit in the grant cycle. `remote_irr` is always 0 for edge lines.
- R4: Granting a level line sets its `remote_irr` bit. While that bit is set, the line produces no further message even though it stays pending.
- R5: `msg_addr` = 0xFEE00000 OR (entry bits 63:48 shifted left by 12) OR (entry bit 11 shifted to address bit 2).
- R6: `msg_data` = vector in bits 7:0, OR entry bits 10:8 (delivery mode) at bits 10:8, OR the trigger bit at bit 15.
- R7: When delivery mode bits 10:8 equal 3'b111, data bits 7:0 come from `ext_vector` and not from entry bits 7:0.
- R8: An `eoi_valid` cycle clears `remote_irr` of every line whose entry bits 7:0 equal `eoi_vector`. Lines with a different vector keep their flag. A matched line that is still pending and unmasked is delivered again.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. A new grant happens only in the cycle after an accept.
- R10: Among eligible lines the lowest index is granted first. Masked lines are never granted.
- R11: After reset `msg_valid`, `pending` and `remote_irr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NPINS | Interrupt input lines |
| route_tbl | input | NPINS*64 | Routing entries, entry i at bits 64*i+63 : 64*i |
| ext_vector | input | 8 | Vector from the external legacy controller |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the EOI broadcast |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| pending | output | NPINS | Per-line pending bits |
| remote_irr | output | NPINS | Per-line remote-IRR flags |

## Verification
Single edge lines with different destinations and modes tell correct field packing apart from a swapped or missing field. A masked edge that is later unmasked separates discarding the edge from deferring it. A held level line crossed with a non-matching EOI and then a matching EOI shows whether coalescing, vector matching and redelivery are right. Raising several edge lines in the same cycle while the receiver stalls shows the grant order and whether the held message stays stable. A line in external-vector mode tells the two vector sources apart.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int ENT_W = 64;
    localparam int VEC_W = 8;

    // routing entry field positions
    localparam int DM_LSB    = 8;
    localparam int DMODE_BIT = 11;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    localparam int DEST_LSB  = 48;

    // message layout
    localparam logic [31:0] MSG_BASE      = 32'hFEE0_0000;
    localparam int          ADDR_DEST_LSB = 12;
    localparam int          ADDR_DMODE    = 2;
    localparam int          DATA_DM_LSB   = 8;
    localparam int          DATA_TRIG     = 15;
    localparam logic [2:0]  DM_EXTERNAL   = 3'b111;

    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_SEND = 1'b1
    } eng_state_t;
endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lines,
    input  logic [NPINS-1:0] lvl_mode,
    input  logic [NPINS-1:0] masked,
    input  logic [NPINS-1:0] edge_clr,
    output logic [NPINS-1:0] pend
);
    logic [NPINS-1:0] lines_q;
    logic [NPINS-1:0] rise;

    assign rise = lines & ~lines_q & ~masked;   // R2: masked edges dropped

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= '0;
            pend    <= '0;
        end else begin
            lines_q <= lines;
            // R1 level follows input, R3 edge cleared on grant (new edge wins)
            pend <= (lvl_mode & lines) |
                    (~lvl_mode & ((pend & ~edge_clr) | rise));
        end
    end
endmodule

// File: rtl/irq_rirr_track.sv
module irq_rirr_track #(
    parameter int NPINS = 24,
    parameter int VEC_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       lvl_mode,
    input  logic [NPINS*VEC_W-1:0] vec_flat,
    input  logic                   eoi_valid,
    input  logic [VEC_W-1:0]       eoi_vec,
    input  logic [NPINS-1:0]       rirr_set,
    output logic [NPINS-1:0]       rirr
);
    logic [NPINS-1:0] eoi_hit;

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_match
            assign eoi_hit[g] = eoi_valid && (vec_flat[g*VEC_W +: VEC_W] == eoi_vec);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rirr <= '0;
        end else begin
            // R8 clear on matching EOI, R4 set on grant, R3 never for edge
            rirr <= lvl_mode & ((rirr & ~eoi_hit) | rirr_set);
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NPINS = 24,
    localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [NPINS-1:0] req,
    output logic             found,
    output logic [IDXW-1:0]  idx
);
    // R10: lowest index wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_msg_fmt.sv
module irq_msg_fmt
    import irq_route_pkg::*;
(
    input  logic [VEC_W-1:0] vec,
    input  logic [2:0]       dm,
    input  logic             dmode,
    input  logic             trig,
    input  logic [15:0]      dest,
    input  logic [VEC_W-1:0] ext_vec,
    output logic [31:0]      addr,
    output logic [31:0]      data
);
    logic [VEC_W-1:0] eff_vec;

    assign eff_vec = (dm == DM_EXTERNAL) ? ext_vec : vec;          // R7
    assign addr = MSG_BASE | ({16'h0, dest} << ADDR_DEST_LSB)
                           | (32'(dmode) << ADDR_DMODE);           // R5
    assign data = 32'(eff_vec) | (32'(dm) << DATA_DM_LSB)
                               | (32'(trig) << DATA_TRIG);         // R6
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
    import irq_route_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       irq_in,
    input  logic [NPINS*ENT_W-1:0] route_tbl,
    input  logic [VEC_W-1:0]       ext_vector,
    input  logic                   eoi_valid,
    input  logic [VEC_W-1:0]       eoi_vector,
    output logic                   msg_valid,
    input  logic                   msg_ready,
    output logic [31:0]            msg_addr,
    output logic [31:0]            msg_data,
    output logic [NPINS-1:0]       pending,
    output logic [NPINS-1:0]       remote_irr
);
    localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1;

    logic [NPINS-1:0]       lvl_mode;
    logic [NPINS-1:0]       masked;
    logic [NPINS*VEC_W-1:0] vec_flat;
    logic [NPINS-1:0]       eligible;
    logic [NPINS-1:0]       gnt_vec;
    logic [NPINS-1:0]       edge_clr;
    logic [NPINS-1:0]       rirr_set;
    logic                   found;
    logic [IDXW-1:0]        sel_idx;
    logic                   gnt;
    logic [31:0]            fmt_addr;
    logic [31:0]            fmt_data;
    logic                   unused_tbl;
    eng_state_t             state_q;
    eng_state_t             state_d;

    assign unused_tbl = ^route_tbl;

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_decode
            assign lvl_mode[g]                = route_tbl[g*ENT_W + TRIG_BIT];
            assign masked[g]                  = route_tbl[g*ENT_W + MASK_BIT];
            assign vec_flat[g*VEC_W +: VEC_W] = route_tbl[g*ENT_W +: VEC_W];
        end
    endgenerate

    irq_pend_track #(.NPINS(NPINS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (irq_in),
        .lvl_mode (lvl_mode),
        .masked   (masked),
        .edge_clr (edge_clr),
        .pend     (pending)
    );

    irq_rirr_track #(.NPINS(NPINS), .VEC_W(VEC_W)) u_rirr (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_mode  (lvl_mode),
        .vec_flat  (vec_flat),
        .eoi_valid (eoi_valid),
        .eoi_vec   (eoi_vector),
        .rirr_set  (rirr_set),
        .rirr      (remote_irr)
    );

    // R4/R10: unmasked, pending, and for level lines no remote IRR
    assign eligible = pending & ~masked & (~lvl_mode | ~remote_irr);

    irq_pick #(.NPINS(NPINS)) u_pick (
        .req   (eligible),
        .found (found),
        .idx   (sel_idx)
    );

    irq_msg_fmt u_fmt (
        .vec     (route_tbl[sel_idx*ENT_W +: VEC_W]),
        .dm      (route_tbl[sel_idx*ENT_W + DM_LSB +: 3]),
        .dmode   (route_tbl[sel_idx*ENT_W + DMODE_BIT]),
        .trig    (route_tbl[sel_idx*ENT_W + TRIG_BIT]),
        .dest    (route_tbl[sel_idx*ENT_W + DEST_LSB +: 16]),
        .ext_vec (ext_vector),
        .addr    (fmt_addr),
        .data    (fmt_data)
    );

    assign gnt      = (state_q == ST_SCAN) && found;
    assign gnt_vec  = gnt ? (NPINS'(1) << sel_idx) : '0;
    assign edge_clr = gnt_vec & ~lvl_mode;
    assign rirr_set = gnt_vec & lvl_mode;

    // next-state logic: grant / idle / accept / stall
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN: if (found)     state_d = ST_SEND;
            ST_SEND: if (msg_ready) state_d = ST_SCAN;
            default:                state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SCAN;
        else        state_q <= state_d;
    end

    // output registers, loaded only on a grant (R9 hold)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_addr <= '0;
            msg_data <= '0;
        end else if (gnt) begin
            msg_addr <= fmt_addr;
            msg_data <= fmt_data;
        end
    end

    assign msg_valid = (state_q == ST_SEND);
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter int NPINS = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPINS*ENT_W-1:0] route_tbl,
    input logic                   eoi_valid,
    input logic [VEC_W-1:0]       eoi_vector,
    input logic                   msg_valid,
    input logic                   msg_ready,
    input logic [31:0]            msg_addr,
    input logic [31:0]            msg_data,
    input logic [NPINS-1:0]       pending,
    input logic [NPINS-1:0]       remote_irr
);
    logic [NPINS-1:0] c_lvl;
    logic [NPINS-1:0] c_msk;
    logic             unused_chk;

    assign unused_chk = ^route_tbl;

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_pin
            assign c_lvl[g] = route_tbl[g*ENT_W + TRIG_BIT];
            assign c_msk[g] = route_tbl[g*ENT_W + MASK_BIT];

            p_masked_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (!c_lvl[g] && c_msk[g] && !pending[g]) |=> !pending[g]);

            p_eoi_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (eoi_valid && remote_irr[g] &&
                 route_tbl[g*ENT_W +: VEC_W] == eoi_vector) |=> !remote_irr[g]);
        end
    endgenerate

    p_hold_msg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    p_addr_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[31:28] == 4'hF && msg_addr[1:0] == 2'b00));

    p_edge_no_rirr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((remote_irr & ~$past(c_lvl)) == '0));

    p_level_sets_rirr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(msg_valid) && msg_data[DATA_TRIG]) |-> (remote_irr != '0));
endmodule

bind irq_route_engine irq_route_chk #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .route_tbl  (route_tbl),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data),
    .pending    (pending),
    .remote_irr (remote_irr)
);

// File: tb/irq_route_engine_tb.sv
`timescale 1ns/1ps
module irq_route_engine_tb;
    localparam int NP = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    irq_in = '0;
    logic [NP*64-1:0] route_tbl;
    logic [7:0]       ext_vector = 8'h00;
    logic             eoi_valid = 1'b0;
    logic [7:0]       eoi_vector = 8'h00;
    logic             msg_valid;
    logic             msg_ready = 1'b0;
    logic [31:0]      msg_addr;
    logic [31:0]      msg_data;
    logic [NP-1:0]    pending;
    logic [NP-1:0]    remote_irr;

    logic [63:0] tbl [NP];

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // reference model state
    logic [NP-1:0] m_pend, m_rirr, m_prev;
    logic          m_valid;
    logic [31:0]   m_addr, m_data;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) route_tbl[i*64 +: 64] = tbl[i];
    end

    irq_route_engine #(.NPINS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .route_tbl(route_tbl),
        .ext_vector(ext_vector), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data), .pending(pending), .remote_irr(remote_irr)
    );

    function automatic logic [31:0] exp_addr(logic [63:0] e);
        return 32'hFEE0_0000 | ({16'h0, e[63:48]} << 12) | (e[11] ? 32'd4 : 32'd0);
    endfunction

    function automatic logic [31:0] exp_data(logic [63:0] e, logic [7:0] ext);
        logic [7:0] v;
        v = (e[10:8] == 3'b111) ? ext : e[7:0];
        return {16'h0, e[15], 4'h0, e[10:8], v};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin : ref_model
        logic [NP-1:0] lvl, msk, hit, elig, gv;
        int sel;
        if (!rst_n) begin
            m_pend = '0; m_rirr = '0; m_prev = '0;
            m_valid = 1'b0; m_addr = '0; m_data = '0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                lvl[i] = tbl[i][15];
                msk[i] = tbl[i][16];
                hit[i] = eoi_valid && (tbl[i][7:0] == eoi_vector);
            end
            elig = m_pend & ~msk & (~lvl | ~m_rirr);
            sel = -1;
            gv  = '0;
            if (!m_valid) begin
                for (int i = NP - 1; i >= 0; i--) if (elig[i]) sel = i;
            end
            if (sel >= 0) begin
                gv[sel] = 1'b1;
                m_addr  = exp_addr(tbl[sel]);
                m_data  = exp_data(tbl[sel], ext_vector);
                m_valid = 1'b1;
            end else if (m_valid && msg_ready) begin
                m_valid = 1'b0;
            end
            m_pend = (lvl & irq_in) | (~lvl & ((m_pend & ~gv) | (irq_in & ~m_prev & ~msk)));
            m_rirr = lvl & ((m_rirr & ~hit) | gv);
            m_prev = irq_in;
        end
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 valid", {31'h0, msg_valid}, {31'h0, m_valid});
            if (m_valid) begin
                chk("R5 addr", msg_addr, m_addr);
                chk("R6 data", msg_data, m_data);
            end
            chk("R1 pending", 32'(pending), 32'(m_pend));
            chk("R4 remote_irr", 32'(remote_irr), 32'(m_rirr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic set_ent(int i, logic [7:0] vec, logic [2:0] dm, logic dmode,
                           logic lvl, logic msk, logic [15:0] dest);
        tbl[i] = {dest, 31'h0, msk, lvl, 1'b0, 2'b00, dmode, dm, vec};
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_msg(string tag);
        int k;
        k = 0;
        while (!msg_valid && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk(tag, {31'h0, msg_valid}, 32'h1);
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic eoi(logic [7:0] v);
        eoi_valid  = 1'b1;
        eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] held;
        for (int i = 0; i < NP; i++) set_ent(i, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 msg_valid", {31'h0, msg_valid}, 32'h0);
        chk("R11 pending", 32'(pending), 32'h0);
        chk("R11 remote_irr", 32'(remote_irr), 32'h0);

        // edge line 3: address / data packing
        set_ent(3, 8'h41, 3'd0, 1'b1, 1'b0, 1'b0, 16'h00AB);
        irq_in[3] = 1'b1;
        wait_msg("R3 edge delivers");
        chk("R5 addr pin3", msg_addr, 32'hFEEA_B004);
        chk("R6 data pin3", msg_data, 32'h0000_0041);
        chk("R3 pending cleared", {31'h0, pending[3]}, 32'h0);
        chk("R3 no remote irr", {31'h0, remote_irr[3]}, 32'h0);
        accept();
        irq_in[3] = 1'b0;
        step(2);

        // masked edge line 5 is discarded
        set_ent(5, 8'h45, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0002);
        irq_in[5] = 1'b1;
        step(3);
        chk("R2 masked edge not pending", {31'h0, pending[5]}, 32'h0);
        chk("R2 masked edge no msg", {31'h0, msg_valid}, 32'h0);
        set_ent(5, 8'h45, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0002);
        step(3);
        chk("R2 unmask no late msg", {31'h0, msg_valid}, 32'h0);
        irq_in[5] = 1'b0;
        step(2);

        // level line 7: coalescing and EOI
        set_ent(7, 8'h52, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0010);
        irq_in[7] = 1'b1;
        wait_msg("R4 level delivers");
        chk("R6 data level", msg_data, 32'h0000_8152);
        chk("R4 remote irr set", {31'h0, remote_irr[7]}, 32'h1);
        accept();
        step(5);
        chk("R4 coalesced", {31'h0, msg_valid}, 32'h0);
        chk("R1 level pending held", {31'h0, pending[7]}, 32'h1);
        eoi(8'h99);
        @(negedge clk);
        chk("R8 other vector kept", {31'h0, remote_irr[7]}, 32'h1);
        eoi(8'h52);
        wait_msg("R8 redelivery after EOI");
        chk("R8 redelivered data", msg_data, 32'h0000_8152);
        accept();
        irq_in[7] = 1'b0;
        step(2);
        chk("R1 level pending drops", {31'h0, pending[7]}, 32'h0);
        eoi(8'h52);
        step(3);
        chk("R8 cleared after EOI", {31'h0, remote_irr[7]}, 32'h0);
        chk("R8 no msg without level", {31'h0, msg_valid}, 32'h0);

        // priority and stall
        set_ent(2, 8'h62, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0001);
        set_ent(4, 8'h64, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0004);
        set_ent(10, 8'h6A, 3'd0, 1'b0, 1'b0, 1'b0, 16'h000A);
        irq_in[2] = 1'b1; irq_in[4] = 1'b1; irq_in[10] = 1'b1;
        wait_msg("R10 first grant");
        chk("R10 lowest first", {24'h0, msg_data[7:0]}, 32'h64);
        held = msg_data;
        step(4);
        chk("R9 valid held", {31'h0, msg_valid}, 32'h1);
        chk("R9 data held", msg_data, held);
        accept();
        wait_msg("R10 second grant");
        chk("R10 next index", {24'h0, msg_data[7:0]}, 32'h6A);
        accept();
        step(3);
        chk("R10 masked skipped", {31'h0, msg_valid}, 32'h0);
        irq_in[2] = 1'b0; irq_in[4] = 1'b0; irq_in[10] = 1'b0;
        step(2);

        // external vector source
        ext_vector = 8'hC3;
        set_ent(12, 8'h11, 3'd7, 1'b0, 1'b0, 1'b0, 16'h0003);
        irq_in[12] = 1'b1;
        wait_msg("R7 external delivers");
        chk("R7 external vector", msg_data, 32'h0000_07C3);
        accept();
        irq_in[12] = 1'b0;
        step(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule